// File: doc/BRIEF.md
# Priority-Level Maskable Interrupt Controller

This block holds the request state for a fixed set of maskable interrupt sources and selects the one the processor should take next. Each source owns a latched request bit and a 3-bit level. A single-cycle pulse on a source's request input sets its bit, and the bit stays set until the request is serviced or cleared by software. Every cycle the block looks for eligible sources. A source is eligible when the global enable input is 1, its bit is set, and its level is strictly above the processor's current priority level. Among the eligible sources, the one with the highest level wins.

The processor drives the global enable and its current priority level on plain control pins. When it takes the vector, it pulses the acknowledge strobe. A small write port lets software clear request bits and program levels. A read port returns one source's bit and level. The block moves no data stream, so it has no valid/ready handshake. Every pin is a plain control or status signal that takes effect on the clock edge where it is sampled.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, every request bit and every level field reads 0 and `irq_pend` is 0.
- R2: A one-cycle pulse on `req_pulse[i]` sets request bit i on that clock edge. The bit stays 1 until an acknowledge or a software clear removes it.
- R3: A write with `sw_sel`=0 addresses the request bit of source `sw_idx`. If `sw_wdata[0]`=0 the bit is cleared. If `sw_wdata[0]`=1 the bit is left unchanged.
- R4: A source with level 0 is never selected, even when its request bit is 1.
- R5: A source is eligible only if its level is strictly greater than `cur_lvl`. With `cur_lvl`=7, no source is eligible.
- R6: While `glb_en`=0, `irq_pend` is 0 and no request bit changes because of an acknowledge.
- R7: Among eligible sources, the highest level wins. Ties at the same level go to the lowest index. `win_idx` and `win_lvl` report the winner.
- R8: `ack` with `irq_pend`=1 clears the winner's request bit on that edge and leaves the other bits alone. `ack` with `irq_pend`=0 changes nothing.
- R9: A request pulse on the same edge as an acknowledge or software clear of that source leaves the bit at 1.
- R10: A write with `sw_sel`=1 sets the level of source `sw_idx` to `sw_wdata`. It changes no request bit and no other level. A request-bit write changes no level.
- R11: `irq_pend`, `win_idx`, `win_lvl`, `rd_req` and `rd_lvl` are combinational from the stored state and the present inputs. A state update is visible in the cycle right after its edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_pulse | input | NSRC | Per-source request pulses |
| ack | input | 1 | Vector-acknowledge strobe |
| glb_en | input | 1 | Global maskable interrupt enable |
| cur_lvl | input | LVLW | Processor current priority level |
| sw_we | input | 1 | Software write strobe |
| sw_sel | input | 1 | Write target: 0 request bit, 1 level |
| sw_idx | input | IDXW | Source addressed by the write |
| sw_wdata | input | LVLW | Write data (bit 0 for request writes) |
| rd_idx | input | IDXW | Source addressed by the read port |
| rd_req | output | 1 | Request bit of source `rd_idx` |
| rd_lvl | output | LVLW | Level of source `rd_idx` |
| irq_pend | output | 1 | An eligible request exists |
| win_idx | output | IDXW | Index of the winning source |
| win_lvl | output | LVLW | Level of the winning source |

## Verification
Three events can land on the same request bit in one cycle: a new request pulse, and either the automatic clear from an acknowledge or a software clear. The bench provokes this in three ways. It raises `ack` together with a pulse on the current winner. It issues a software clear together with a pulse on the same source. It raises `ack` together with a pulse on a different, idle source. In each case it reads the request bits back through the read port, and the new winner through `win_idx`, to confirm that the pulse survived and that only the winner was cleared.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  typedef enum logic {
    SEL_REQ = 1'b0,
    SEL_LVL = 1'b1
  } sw_sel_e;
endpackage

// File: rtl/prio_irq_src.sv
module prio_irq_src #(
  parameter int LVLW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pulse,
  input  logic            ack_hit,
  input  logic            clr_hit,
  input  logic            lvl_we,
  input  logic [LVLW-1:0] lvl_wdata,
  output logic            req_q,
  output logic [LVLW-1:0] lvl_q
);
  // a new pulse outranks any clear on the same edge
  logic req_d;
  assign req_d = (req_q & ~ack_hit & ~clr_hit) | pulse;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      lvl_q <= '0;
    end else begin
      req_q <= req_d;
      if (lvl_we) lvl_q <= lvl_wdata;
    end
  end
endmodule

// File: rtl/prio_irq_arb.sv
module prio_irq_arb #(
  parameter int NSRC = 8,
  parameter int LVLW = 3,
  localparam int IDXW = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]           req,
  input  logic [NSRC-1:0][LVLW-1:0] lvl,
  input  logic                      glb_en,
  input  logic [LVLW-1:0]           cur_lvl,
  output logic                      pend,
  output logic [IDXW-1:0]           win_idx,
  output logic [LVLW-1:0]           win_lvl
);
  always_comb begin
    pend    = 1'b0;
    win_idx = '0;
    win_lvl = '0;
    for (int i = 0; i < NSRC; i++) begin
      // strict compare keeps the lowest index on ties
      if (glb_en && req[i] && (lvl[i] > cur_lvl) && (!pend || lvl[i] > win_lvl)) begin
        pend    = 1'b1;
        win_idx = IDXW'(i);
        win_lvl = lvl[i];
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NSRC = 8,
  parameter int LVLW = 3,
  localparam int IDXW = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req_pulse,
  input  logic            ack,
  input  logic            glb_en,
  input  logic [LVLW-1:0] cur_lvl,
  input  logic            sw_we,
  input  logic            sw_sel,
  input  logic [IDXW-1:0] sw_idx,
  input  logic [LVLW-1:0] sw_wdata,
  input  logic [IDXW-1:0] rd_idx,
  output logic            rd_req,
  output logic [LVLW-1:0] rd_lvl,
  output logic            irq_pend,
  output logic [IDXW-1:0] win_idx,
  output logic [LVLW-1:0] win_lvl
);
  import prio_irq_pkg::*;

  logic [NSRC-1:0]           req_q;
  logic [NSRC-1:0][LVLW-1:0] lvl_q;
  sw_sel_e                   sel;

  assign sel = sw_sel_e'(sw_sel);

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic hit_sw, hit_ack, hit_lvl;
    assign hit_ack = ack && irq_pend && (win_idx == IDXW'(g));
    assign hit_sw  = sw_we && (sel == SEL_REQ) && (sw_idx == IDXW'(g)) && !sw_wdata[0];
    assign hit_lvl = sw_we && (sel == SEL_LVL) && (sw_idx == IDXW'(g));

    prio_irq_src #(.LVLW(LVLW)) u_src (
      .clk       (clk),
      .rst_n     (rst_n),
      .pulse     (req_pulse[g]),
      .ack_hit   (hit_ack),
      .clr_hit   (hit_sw),
      .lvl_we    (hit_lvl),
      .lvl_wdata (sw_wdata),
      .req_q     (req_q[g]),
      .lvl_q     (lvl_q[g])
    );
  end

  prio_irq_arb #(.NSRC(NSRC), .LVLW(LVLW)) u_arb (
    .req     (req_q),
    .lvl     (lvl_q),
    .glb_en  (glb_en),
    .cur_lvl (cur_lvl),
    .pend    (irq_pend),
    .win_idx (win_idx),
    .win_lvl (win_lvl)
  );

  assign rd_req = req_q[rd_idx];
  assign rd_lvl = lvl_q[rd_idx];
endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk #(
  parameter int NSRC = 8,
  parameter int LVLW = 3,
  localparam int IDXW = $clog2(NSRC)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] req_pulse,
  input logic            ack,
  input logic            glb_en,
  input logic [LVLW-1:0] cur_lvl,
  input logic            irq_pend,
  input logic [IDXW-1:0] win_idx,
  input logic [LVLW-1:0] win_lvl,
  input logic [NSRC-1:0] req_q
);
  // R6
  no_pend_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |-> !irq_pend);

  // R5
  win_above_cur_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pend |-> (win_lvl > cur_lvl));

  // R4
  win_lvl_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pend |-> (win_lvl != '0));

  // R2
  pulse_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(req_pulse) & ~req_q) == '0));

  // R3
  no_sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((req_q & ~$past(req_q) & ~$past(req_pulse)) == '0));

  // R8
  ack_clears_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_pend && !req_pulse[win_idx]) |=> !req_q[$past(win_idx)]);
endmodule

bind prio_irq_ctrl prio_irq_chk #(.NSRC(NSRC), .LVLW(LVLW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_pulse (req_pulse),
  .ack       (ack),
  .glb_en    (glb_en),
  .cur_lvl   (cur_lvl),
  .irq_pend  (irq_pend),
  .win_idx   (win_idx),
  .win_lvl   (win_lvl),
  .req_q     (req_q)
);

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb;
  localparam int NSRC = 8;
  localparam int LVLW = 3;
  localparam int IDXW = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] req_pulse = '0;
  logic            ack = 1'b0;
  logic            glb_en = 1'b0;
  logic [LVLW-1:0] cur_lvl = '0;
  logic            sw_we = 1'b0;
  logic            sw_sel = 1'b0;
  logic [IDXW-1:0] sw_idx = '0;
  logic [LVLW-1:0] sw_wdata = '0;
  logic [IDXW-1:0] rd_idx = '0;
  logic            rd_req;
  logic [LVLW-1:0] rd_lvl;
  logic            irq_pend;
  logic [IDXW-1:0] win_idx;
  logic [LVLW-1:0] win_lvl;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  prio_irq_ctrl #(.NSRC(NSRC), .LVLW(LVLW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_pulse(req_pulse), .ack(ack),
    .glb_en(glb_en), .cur_lvl(cur_lvl), .sw_we(sw_we), .sw_sel(sw_sel),
    .sw_idx(sw_idx), .sw_wdata(sw_wdata), .rd_idx(rd_idx),
    .rd_req(rd_req), .rd_lvl(rd_lvl), .irq_pend(irq_pend),
    .win_idx(win_idx), .win_lvl(win_lvl)
  );

  task automatic chk(string rq, int act, int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  // all drive tasks start and end at a falling edge
  task automatic sw_write(bit sel, int idx, int data);
    sw_we = 1'b1; sw_sel = sel; sw_idx = IDXW'(idx); sw_wdata = LVLW'(data);
    @(negedge clk);
    sw_we = 1'b0;
  endtask

  task automatic pulse(logic [NSRC-1:0] m);
    req_pulse = m;
    @(negedge clk);
    req_pulse = '0;
  endtask

  task automatic do_ack(logic [NSRC-1:0] m);
    ack = 1'b1; req_pulse = m;
    @(negedge clk);
    ack = 1'b0; req_pulse = '0;
  endtask

  task automatic rd(int idx, output int r, output int l);
    rd_idx = IDXW'(idx);
    #0.5;
    r = int'(rd_req);
    l = int'(rd_lvl);
  endtask

  task automatic clean();
    for (int i = 0; i < NSRC; i++) begin
      sw_write(1'b0, i, 0);
      sw_write(1'b1, i, 0);
    end
    glb_en = 1'b0; cur_lvl = '0;
  endtask

  task automatic t_reset();
    int r, l;
    for (int i = 0; i < NSRC; i++) begin
      rd(i, r, l);
      chk("R1 req", r, 0);
      chk("R1 lvl", l, 0);
    end
    chk("R1 pend", int'(irq_pend), 0);
  endtask

  task automatic t_latch_level();
    int r, l;
    glb_en = 1'b1; cur_lvl = 0;
    pulse(8'h08);
    rd(3, r, l);
    chk("R2 latched", r, 1);
    chk("R4 lvl0 not pending", int'(irq_pend), 0);
    repeat (3) @(negedge clk);
    rd(3, r, l);
    chk("R2 held", r, 1);
    sw_write(1'b1, 3, 2);
    #0.5;
    chk("R11 pend after lvl write", int'(irq_pend), 1);
    chk("R11 win idx", int'(win_idx), 3);
    chk("R11 win lvl", int'(win_lvl), 2);
  endtask

  task automatic t_threshold();
    cur_lvl = 2; #0.5;
    chk("R5 equal level blocked", int'(irq_pend), 0);
    cur_lvl = 1; #0.5;
    chk("R5 above level accepted", int'(irq_pend), 1);
    sw_write(1'b1, 3, 7);
    cur_lvl = 7; #0.5;
    chk("R5 cur 7 blocks all", int'(irq_pend), 0);
    cur_lvl = 6; #0.5;
    chk("R5 lvl7 over cur6", int'(irq_pend), 1);
  endtask

  task automatic t_enable();
    int r, l;
    glb_en = 1'b0; #0.5;
    chk("R6 disabled no pend", int'(irq_pend), 0);
    do_ack('0);
    rd(3, r, l);
    chk("R6 ack while off keeps req", r, 1);
    chk("R8 ack without pend no change", r, 1);
    glb_en = 1'b1; #0.5;
    chk("R6 re-enable pend", int'(irq_pend), 1);
  endtask

  task automatic t_sw();
    int r, l;
    clean();
    sw_write(1'b0, 5, 1);
    rd(5, r, l);
    chk("R3 write 1 no set", r, 0);
    pulse(8'h20);
    sw_write(1'b0, 5, 1);
    rd(5, r, l);
    chk("R3 write 1 keeps set", r, 1);
    sw_write(1'b0, 5, 0);
    rd(5, r, l);
    chk("R3 write 0 clears", r, 0);
  endtask

  task automatic t_priority();
    clean();
    glb_en = 1'b1; cur_lvl = 0;
    sw_write(1'b1, 5, 5);
    sw_write(1'b1, 1, 5);
    sw_write(1'b1, 6, 6);
    pulse(8'h62);
    #0.5;
    chk("R7 highest idx", int'(win_idx), 6);
    chk("R7 highest lvl", int'(win_lvl), 6);
    sw_write(1'b0, 6, 0);
    #0.5;
    chk("R7 tie lowest idx", int'(win_idx), 1);
    chk("R7 tie lvl", int'(win_lvl), 5);
    cur_lvl = 5; #0.5;
    chk("R5 both at cur blocked", int'(irq_pend), 0);
  endtask

  task automatic t_ack();
    int r, l;
    clean();
    glb_en = 1'b1; cur_lvl = 0;
    sw_write(1'b1, 2, 3);
    sw_write(1'b1, 4, 4);
    pulse(8'h14);
    #0.5;
    chk("R7 win before ack", int'(win_idx), 4);
    do_ack('0);
    rd(4, r, l);
    chk("R8 winner cleared", r, 0);
    rd(2, r, l);
    chk("R8 other kept", r, 1);
    chk("R8 next winner", int'(win_idx), 2);
  endtask

  task automatic t_collide();
    int r, l;
    do_ack(8'h04);
    rd(2, r, l);
    chk("R9 ack+pulse keeps req", r, 1);
    chk("R9 still pending", int'(irq_pend), 1);
    req_pulse = 8'h04;
    sw_write(1'b0, 2, 0);
    req_pulse = '0;
    rd(2, r, l);
    chk("R9 clear+pulse keeps req", r, 1);
    do_ack(8'h10);
    rd(2, r, l);
    chk("R9 ack clears winner", r, 0);
    rd(4, r, l);
    chk("R9 other pulse set", r, 1);
    chk("R9 new winner", int'(win_idx), 4);
  endtask

  task automatic t_indep();
    int r, l;
    pulse(8'h04);
    sw_write(1'b1, 0, 7);
    rd(2, r, l);
    chk("R10 lvl write keeps req2", r, 1);
    rd(4, r, l);
    chk("R10 lvl write keeps req4", r, 1);
    chk("R10 other lvl kept", l, 4);
    rd(0, r, l);
    chk("R10 lvl written", l, 7);
    chk("R10 lvl write sets no req", r, 0);
    sw_write(1'b0, 4, 0);
    rd(4, r, l);
    chk("R10 req clear keeps lvl", l, 4);
    chk("R3 cleared", r, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latch_level();
    t_threshold();
    t_enable();
    t_sw();
    t_priority();
    t_ack();
    t_collide();
    t_indep();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule